// File: doc/BRIEF.md
# Serial Clock Phase Generator

This block makes the serial clock and the per-bit timing strobes for a synchronous serial shifter. A single master clock drives it. A fixed divide-by-5 prescaler can sit in front of a programmable half-period counter, and the counter then sets the length of each phase of a bit. The shifter asks for one bit with `shift_req`. The block answers with a setup strobe when the bit starts, drives the clock high for one half-period and low again, and pulses `bit_done` when the bit's last phase ends.

Single-cycle opcode strobes set three mode flags:
- **Prescaler:** on or off.
- **Phase timing:** two-phase (setup, then pulse) or three-phase. Three-phase adds a hold half-period after the clock falls, so that a two-wire bus sees the data stable around both edges.
- **Adaptive clocking:** in this mode no clock edge may follow another until the target's returned clock, after double synchronisation, matches the level being driven.

Top module: `sclk_phase_gen`

## Requirements
- R1: After synchronous reset, `sclk_out`, `setup_stb`, `hold_stb` and `bit_done` are low. The prescaler is on, timing is two-phase and adaptive mode is off.
- R2: Opcode 0x8A turns the prescaler off, so one tick occurs per master clock. Opcode 0x8B turns it back on, so one tick occurs every 5 master clocks. `sclk_out` changes only in the cycle after a tick, so the clock-high time is (divisor+1) cycles with the prescaler off and 5*(divisor+1) cycles with it on.
- R3: In two-phase timing a bit is a setup phase with the clock low, then a pulse phase with the clock high. Each phase lasts (divisor+1) ticks, where divisor is 16 bits. `bit_done` pulses in the cycle the clock falls. With the prescaler off, `bit_done` rises 2*(divisor+1) cycles after `setup_stb`.
- R4: Opcode 0x8C selects three-phase timing. `hold_stb` pulses in the cycle the clock falls, and `bit_done` pulses (divisor+1) ticks later, with the clock still low. Opcode 0x8D returns to two-phase timing, in which `hold_stb` never pulses.
- R5: `setup_stb`, `hold_stb` and `bit_done` are each one cycle wide, and no two are high in the same cycle. `setup_stb` rises in the cycle after an idle block samples `shift_req` high.
- R6: A `shift_req` that arrives while a bit is in progress is ignored: it neither restarts nor extends the bit, and no further bit follows.
- R7: Opcode 0x96 enables adaptive mode. A phase cannot end until the twice-registered `rtck_in` equals the current `sclk_out`. A change on `rtck_in` therefore lets an overdue clock edge happen on the third master-clock edge after it.
- R8: Opcode 0x97 disables adaptive mode, after which `rtck_in` has no effect on timing.
- R9: Any opcode other than 0x8A, 0x8B, 0x8C, 0x8D, 0x96 and 0x97 leaves all three modes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode strobe, one cycle |
| op_code | input | 8 | Opcode value, read when op_valid is high |
| shift_req | input | 1 | Request one bit; sampled only while idle |
| divisor | input | 16 | Half-period length minus one, in ticks |
| rtck_in | input | 1 | Returned clock from the target (asynchronous) |
| sclk_out | output | 1 | Serial clock pin |
| setup_stb | output | 1 | Start of a bit's data-setup phase |
| hold_stb | output | 1 | Start of the hold phase (three-phase only) |
| bit_done | output | 1 | End of the bit's last phase |

## Verification
The checker watches several properties on every cycle:
- the strobes are single-cycle and never overlap;
- `hold_stb` coincides with a falling clock;
- `bit_done` arrives only with the clock low;
- every clock edge follows a prescaler tick;
- in adaptive mode, no edge occurs unless the synchronised returned clock matched the driven level.

Only the bench scenarios can show the actual phase lengths for each divisor and prescaler setting. They also show the three-cycle delay from a returned-clock change to the overdue edge, that requests made mid-bit are dropped, and that unknown opcodes leave the modes alone.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam logic [7:0] OP_PRESCALE_OFF = 8'h8A;
    localparam logic [7:0] OP_PRESCALE_ON  = 8'h8B;
    localparam logic [7:0] OP_TRI_ON       = 8'h8C;
    localparam logic [7:0] OP_TRI_OFF      = 8'h8D;
    localparam logic [7:0] OP_ADAPT_ON     = 8'h96;
    localparam logic [7:0] OP_ADAPT_OFF    = 8'h97;

    localparam int PRESCALE_RATIO = 5;
    localparam int DIV_W          = 16;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic prescale;
        logic tri_phase;
        logic adaptive;
    } mode_t;

    localparam mode_t MODE_RESET = '{prescale: 1'b1, tri_phase: 1'b0, adaptive: 1'b0};

    function automatic mode_t mode_apply(mode_t cur, logic [7:0] op);
        mode_t nxt;
        nxt = cur;
        case (op)
            OP_PRESCALE_OFF: nxt.prescale  = 1'b0;
            OP_PRESCALE_ON:  nxt.prescale  = 1'b1;
            OP_TRI_ON:       nxt.tri_phase = 1'b1;
            OP_TRI_OFF:      nxt.tri_phase = 1'b0;
            OP_ADAPT_ON:     nxt.adaptive  = 1'b1;
            OP_ADAPT_OFF:    nxt.adaptive  = 1'b0;
            default:         nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sclk_mode_regs.sv
module sclk_mode_regs
    import sclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    output mode_t      mode
);
    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (op_valid) begin
            mode_q <= mode_apply(mode_q, op_code);
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
    parameter int RATIO = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic tick
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !enable || (cnt_q == LAST);
endmodule

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] sr_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sr_q[0] <= 1'b0;
                    else     sr_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sr_q[i] <= 1'b0;
                    else     sr_q[i] <= sr_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = sr_q[STAGES-1];
endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import sclk_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          tri_phase,
    input  logic          adaptive,
    input  logic          rtck_s,
    input  logic          shift_req,
    input  logic [DW-1:0] divisor,
    output logic          sclk,
    output logic          setup_stb,
    output logic          hold_stb,
    output logic          bit_done
);
    phase_t        phase_q;
    logic [DW-1:0] cnt_q;
    logic          sclk_q;
    logic          setup_q, hold_q, done_q;

    logic ack_ok, cnt_done, phase_end;

    always_comb begin
        ack_ok    = !adaptive || (rtck_s == sclk_q);
        cnt_done  = (cnt_q >= divisor);
        phase_end = tick && cnt_done && ack_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            sclk_q  <= 1'b0;
            setup_q <= 1'b0;
            hold_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            setup_q <= 1'b0;
            hold_q  <= 1'b0;
            done_q  <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (shift_req) begin
                    phase_q <= PH_SETUP;
                    cnt_q   <= '0;
                    setup_q <= 1'b1;
                end
            end else if (phase_end) begin
                cnt_q <= '0;
                case (phase_q)
                    PH_SETUP: begin
                        phase_q <= PH_PULSE;
                        sclk_q  <= 1'b1;
                    end
                    PH_PULSE: begin
                        sclk_q <= 1'b0;
                        if (tri_phase) begin
                            phase_q <= PH_HOLD;
                            hold_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                endcase
            end else if (tick && !cnt_done) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sclk      = sclk_q;
    assign setup_stb = setup_q;
    assign hold_stb  = hold_q;
    assign bit_done  = done_q;
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
    import sclk_pkg::*;
#(
    parameter int DW       = DIV_W,
    parameter int RATIO    = PRESCALE_RATIO,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [7:0]    op_code,
    input  logic          shift_req,
    input  logic [DW-1:0] divisor,
    input  logic          rtck_in,
    output logic          sclk_out,
    output logic          setup_stb,
    output logic          hold_stb,
    output logic          bit_done
);
    mode_t mode;
    logic  tick;
    logic  rtck_s;
    logic  adaptive_en;

    sclk_mode_regs u_mode (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .mode     (mode)
    );

    sclk_prescaler #(.RATIO(RATIO)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (mode.prescale),
        .tick   (tick)
    );

    sclk_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rtck_in),
        .q_sync  (rtck_s)
    );

    assign adaptive_en = mode.adaptive;

    sclk_phase_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tri_phase (mode.tri_phase),
        .adaptive  (adaptive_en),
        .rtck_s    (rtck_s),
        .shift_req (shift_req),
        .divisor   (divisor),
        .sclk      (sclk_out),
        .setup_stb (setup_stb),
        .hold_stb  (hold_stb),
        .bit_done  (bit_done)
    );
endmodule

// File: rtl/sclk_phase_gen_chk.sv
module sclk_phase_gen_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic adaptive,
    input logic rtck_s,
    input logic sclk,
    input logic setup_stb,
    input logic hold_stb,
    input logic bit_done
);
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({setup_stb, hold_stb, bit_done}));

    a_r5_setup_single: assert property (@(posedge clk) disable iff (rst)
        setup_stb |=> !setup_stb);

    a_r4_hold_at_fall: assert property (@(posedge clk) disable iff (rst)
        hold_stb |-> $fell(sclk));

    a_r3_done_clock_low: assert property (@(posedge clk) disable iff (rst)
        bit_done |-> !sclk);

    a_r2_edge_after_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> $past(tick));

    a_r7_edge_needs_ack: assert property (@(posedge clk) disable iff (rst)
        (adaptive && $past(adaptive) && !$stable(sclk)) |-> ($past(rtck_s) == $past(sclk)));
endmodule

bind sclk_phase_gen sclk_phase_gen_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .adaptive  (adaptive_en),
    .rtck_s    (rtck_s),
    .sclk      (sclk_out),
    .setup_stb (setup_stb),
    .hold_stb  (hold_stb),
    .bit_done  (bit_done)
);

// File: tb/sclk_phase_gen_tb_top.sv
`timescale 1ns/1ps
module sclk_phase_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        shift_req = 1'b0;
    logic [15:0] divisor = 16'd0;
    logic        rtck_in = 1'b0;
    logic        sclk_out, setup_stb, hold_stb, bit_done;

    int checks = 0;
    int errors = 0;
    int t_setup, t_rise, t_fall, t_hold, t_done, n_setup;

    always #2.5 clk = ~clk;

    sclk_phase_gen dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .shift_req(shift_req), .divisor(divisor), .rtck_in(rtck_in),
        .sclk_out(sclk_out), .setup_stb(setup_stb), .hold_stb(hold_stb),
        .bit_done(bit_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_op(input logic [7:0] op);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 8'h00;
    endtask

    // One bit; times are negedge sample indices after shift_req is raised.
    // inject > 0 raises shift_req again for one cycle at that sample.
    task automatic do_bit(input int dv, input int inject);
        int  n;
        logic prev;
        divisor = 16'(dv);
        t_setup = -1; t_rise = -1; t_fall = -1; t_hold = -1; t_done = -1; n_setup = 0;
        @(negedge clk);
        shift_req = 1'b1;
        prev = sclk_out;
        n = 0;
        while (t_done < 0 && n < 4000) begin
            @(negedge clk);
            n++;
            shift_req = (inject > 0 && n == inject);
            if (setup_stb) begin
                n_setup++;
                if (t_setup < 0) t_setup = n;
            end
            if (sclk_out && !prev && t_rise < 0) t_rise = n;
            if (!sclk_out && prev && t_fall < 0) t_fall = n;
            if (hold_stb && t_hold < 0) t_hold = n;
            if (bit_done) t_done = n;
            prev = sclk_out;
        end
        shift_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!sclk_out, "R1 sclk low after reset", int'(sclk_out), 0);
        chk(!setup_stb && !hold_stb && !bit_done, "R1 strobes low after reset",
            int'({setup_stb, hold_stb, bit_done}), 0);
        // R1 default prescaler on, two-phase
        do_bit(1, 0);
        chk(t_fall - t_rise == 10, "R1 default prescaled high time", t_fall - t_rise, 10);
        chk(t_hold < 0, "R1 default two-phase no hold", t_hold, -1);

        // R2 prescaler on: high time 5*(d+1)
        for (int d = 0; d < 4; d++) begin
            do_bit(d, 0);
            chk(t_fall - t_rise == 5 * (d + 1), "R2 prescaled high time", t_fall - t_rise, 5 * (d + 1));
        end

        send_op(8'h8A);
        // R3 two-phase sweep with prescaler off
        for (int d = 0; d < 8; d++) begin
            do_bit(d, 0);
            chk(t_setup == 1, "R5 setup strobe timing", t_setup, 1);
            chk(t_rise == d + 2, "R3 rise time", t_rise, d + 2);
            chk(t_fall == 2 * d + 3, "R3 fall time", t_fall, 2 * d + 3);
            chk(t_done == t_fall, "R3 bit_done at fall", t_done, t_fall);
            chk(t_done - t_setup == 2 * (d + 1), "R3 bit length", t_done - t_setup, 2 * (d + 1));
            chk(t_hold < 0, "R4 no hold in two-phase", t_hold, -1);
        end

        send_op(8'h8C);
        // R4 three-phase sweep
        for (int d = 0; d < 8; d++) begin
            do_bit(d, 0);
            chk(t_hold == t_fall, "R4 hold at fall", t_hold, t_fall);
            chk(t_fall == 2 * d + 3, "R4 fall time", t_fall, 2 * d + 3);
            chk(t_done - t_hold == d + 1, "R4 hold length", t_done - t_hold, d + 1);
            chk(t_done - t_setup == 3 * (d + 1), "R4 bit length", t_done - t_setup, 3 * (d + 1));
        end

        // R6 request mid-bit ignored
        do_bit(3, 4);
        chk(n_setup == 1, "R6 one setup per bit", n_setup, 1);
        chk(t_done - t_setup == 12, "R6 bit not extended", t_done - t_setup, 12);
        begin
            int extra = 0;
            repeat (30) begin
                @(negedge clk);
                if (setup_stb || sclk_out) extra++;
            end
            chk(extra == 0, "R6 no extra bit", extra, 0);
        end

        send_op(8'h8D);
        do_bit(2, 0);
        chk(t_hold < 0, "R4 0x8D back to two-phase", t_hold, -1);
        chk(t_done - t_setup == 6, "R4 two-phase length restored", t_done - t_setup, 6);

        // R9 unknown opcodes leave modes alone
        send_op(8'h00);
        send_op(8'h8E);
        send_op(8'hFF);
        send_op(8'h9C);
        do_bit(2, 0);
        chk(t_fall - t_rise == 3, "R9 prescaler unchanged", t_fall - t_rise, 3);
        chk(t_hold < 0, "R9 phase mode unchanged", t_hold, -1);

        // R7 adaptive: stall until returned clock echoes
        send_op(8'h96);
        divisor = 16'd2;
        rtck_in = 1'b0;
        @(negedge clk);
        shift_req = 1'b1;
        @(negedge clk);
        shift_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(sclk_out, "R7 rise with rtck low in setup", int'(sclk_out), 1);
        repeat (20) @(negedge clk);
        chk(sclk_out, "R7 stall while rtck low", int'(sclk_out), 1);
        rtck_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sclk_out, "R7 still high two edges after rtck", int'(sclk_out), 1);
        @(negedge clk);
        chk(!sclk_out, "R7 fall third edge after rtck", int'(sclk_out), 0);
        chk(bit_done, "R7 bit done at released fall", int'(bit_done), 1);
        rtck_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8 adaptive off: rtck ignored
        send_op(8'h97);
        rtck_in = 1'b0;
        do_bit(2, 0);
        chk(t_fall - t_rise == 3, "R8 rtck ignored low", t_fall - t_rise, 3);
        rtck_in = 1'b1;
        do_bit(2, 0);
        chk(t_rise == 4 && t_fall == 7, "R8 rtck ignored high", t_fall, 7);
        rtck_in = 1'b0;

        // R2 prescaler restored by 0x8B
        send_op(8'h8B);
        do_bit(2, 0);
        chk(t_fall - t_rise == 15, "R2 0x8B restores prescaler", t_fall - t_rise, 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule